// File: doc/BRIEF.md
# VCO Sub-Band Trim Search Sequencer

This block picks the sub-band trim word of a switched-capacitor VCO while the synthesizer loop stays closed. It starts at the highest trim code and applies one code at a time. For each code it waits long enough for the loop to lock and for an outside comparator to settle. It then reads one flag from that comparator. The flag says whether the loop's tuning voltage is above its lower limit. If the flag is set, the current code is stored as the final VCO trim word. If the flag is clear, the sequencer steps one code down and waits again. If the code is already zero, the sequencer stops and reports failure.

A search starts by itself when reset is released, so calibration happens at power-up. Software or a power-up controller can run the search again with a rising edge on the request input once the previous search has finished. The comparator, the reference voltage and the loop itself are all outside this block. The comparator flag arrives asynchronously and is resynchronized inside.

Top module: `vco_trim_seq`

## Requirements
- R1: While reset is applied, and in the first cycle after it, the block reports a running search. The applied code is all ones, the fail flag is 0 and the stored VCO trim word is 0.
- R2: If the comparator flag is 1 at the decision edge that ends a wait, the stored VCO trim word takes the applied code and the busy output goes to 0 in that same edge. The stored word changes at no other time.
- R3: Each applied code is held for exactly WAIT_CYCLES clock cycles. The comparator flag is used only at the edge that ends the wait. The value used is the one the flag had two clock edges earlier, because it passes through a two-flop synchronizer. A pulse on the flag that ends well before the decision edge has no effect.
- R4: If the flag is 0 at the decision edge and the applied code is nonzero, the code drops by exactly one and a new full wait begins. A code of zero is still tried, and it can succeed.
- R5: If the flag is 0 at the decision edge and the applied code is zero, the fail flag goes to 1, the busy output goes to 0 and the stored trim word keeps its old value.
- R6: A search that never sees the flag set ends 2^TRIM_W × WAIT_CYCLES cycles after it starts.
- R7: When the block is idle, a rising edge on the request input starts a fresh search. That edge sets the code to all ones, clears the fail flag and sets the busy output to 1.
- R8: A request edge that arrives while a search is running has no effect on the code sequence or on the busy output.
- R9: When the block is idle, it holds all of its outputs. A request input that stays high does not start another search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; releasing it starts a search |
| cal_req_i | input | 1 | Calibration request; a rising edge starts a search when the block is idle |
| cmp_above_i | input | 1 | Asynchronous comparator flag: tuning voltage is above its lower limit |
| trim_code_o | output | TRIM_W | Trim code currently applied to the VCO during the search |
| vco_trim_o | output | TRIM_W | Stored VCO trim word from the last successful search |
| cal_pending_o | output | 1 | High while a search runs; returns to 0 at success or failure |
| cal_fail_o | output | 1 | Set when the search ran past code zero without success |

## Verification
The bench builds the block with TRIM_W = 3 and WAIT_CYCLES = 16. With these values a full failing search takes 128 cycles, so each scenario finishes in a few hundred cycles. These include success at the top code, success in the middle, success at code zero, exhaustion to failure, a comparator glitch in the middle of a wait, and requests that arrive during a search or are held high while idle. The short wait still leaves many cycles between synchronizer latency and the decision edge. The reference model follows the two-edge comparator delay exactly, so both the ignored glitch and the accepted level are checked on every cycle.

// File: rtl/vts_pkg.sv
package vts_pkg;

    typedef enum logic {
        VTS_SEARCH = 1'b0,
        VTS_IDLE   = 1'b1
    } vts_state_e;

endpackage

// File: rtl/vts_sync2.sv
// Two-flop resynchronizer for an asynchronous level.
module vts_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic meta;
        logic stable;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = async_i;
        sync_d.stable = sync_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '{meta: RST_VAL, stable: RST_VAL};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.stable;

endmodule

// File: rtl/vts_wait_timer.sv
// Settling-interval counter: signals the last cycle of each WAIT_CYCLES window
// while running, and rewinds itself at that point.
module vts_wait_timer #(
    parameter int unsigned WAIT_CYCLES = 50000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic run_i,
    output logic done_o
);

    localparam int unsigned CNT_W = (WAIT_CYCLES > 2) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        done_o = run_i && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = done_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    initial begin
        if (WAIT_CYCLES < 2) $error("WAIT_CYCLES must be at least 2");
    end

endmodule

// File: rtl/vco_trim_seq.sv
// Downward sequential search of the VCO sub-band trim word, judged by a single
// comparator reading at the end of each lock-and-settle interval.
module vco_trim_seq #(
    parameter int unsigned TRIM_W      = 3,
    parameter int unsigned WAIT_CYCLES = 50000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cal_req_i,
    input  logic              cmp_above_i,
    output logic [TRIM_W-1:0] trim_code_o,
    output logic [TRIM_W-1:0] vco_trim_o,
    output logic              cal_pending_o,
    output logic              cal_fail_o
);

    import vts_pkg::*;

    localparam logic [TRIM_W-1:0] CODE_TOP  = '1;
    localparam logic [TRIM_W-1:0] CODE_ZERO = '0;

    typedef struct packed {
        vts_state_e        st;
        logic [TRIM_W-1:0] code;
        logic [TRIM_W-1:0] trim;
        logic              fail;
        logic              req_prev;
    } seq_t;

    seq_t seq_d, seq_q;

    logic cmp_sync;
    logic wait_done;
    logic timer_restart;
    logic req_rise;
    logic searching;

    vts_sync2 #(
        .RST_VAL (1'b0)
    ) i_cmp_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (cmp_above_i),
        .sync_o  (cmp_sync)
    );

    vts_wait_timer #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) i_wait_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (timer_restart),
        .run_i     (searching),
        .done_o    (wait_done)
    );

    assign searching = (seq_q.st == VTS_SEARCH);
    assign req_rise  = cal_req_i && !seq_q.req_prev;

    always_comb begin
        seq_d          = seq_q;
        seq_d.req_prev = cal_req_i;
        timer_restart  = 1'b0;
        unique case (seq_q.st)
            VTS_SEARCH: begin
                if (wait_done) begin
                    if (cmp_sync) begin
                        seq_d.trim = seq_q.code;
                        seq_d.st   = VTS_IDLE;
                    end else if (seq_q.code == CODE_ZERO) begin
                        seq_d.fail = 1'b1;
                        seq_d.st   = VTS_IDLE;
                    end else begin
                        seq_d.code = seq_q.code - 1'b1;
                    end
                end
            end
            VTS_IDLE: begin
                if (req_rise) begin
                    seq_d.st      = VTS_SEARCH;
                    seq_d.code    = CODE_TOP;
                    seq_d.fail    = 1'b0;
                    timer_restart = 1'b1;
                end
            end
            default: seq_d.st = VTS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{st: VTS_SEARCH, code: CODE_TOP, trim: CODE_ZERO,
                       fail: 1'b0, req_prev: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign trim_code_o   = seq_q.code;
    assign vco_trim_o    = seq_q.trim;
    assign cal_pending_o = searching;
    assign cal_fail_o    = seq_q.fail;

endmodule

// File: rtl/vts_checker.sv
module vts_checker #(
    parameter int unsigned TRIM_W = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [TRIM_W-1:0] trim_code_o,
    input logic [TRIM_W-1:0] vco_trim_o,
    input logic              cal_pending_o,
    input logic              cal_fail_o,
    input logic              wait_done_i
);

    // R2: stored word moves only when a search ends in success
    a_r2_trim_only_on_success: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(vco_trim_o) |-> ($fell(cal_pending_o) && !cal_fail_o));

    // R2: a successful end stores the code that was applied
    a_r2_latch_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(cal_pending_o) && !cal_fail_o) |-> (vco_trim_o == trim_code_o));

    // R3: no code change before the settling timer expires
    a_r3_hold_until_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cal_pending_o && $past(cal_pending_o) && !$past(wait_done_i)) |-> $stable(trim_code_o));

    // R4: within a search the code only steps down by one
    a_r4_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cal_pending_o && $past(cal_pending_o) && !$stable(trim_code_o))
            |-> (trim_code_o == TRIM_W'($past(trim_code_o) - 1)));

    // R5: failure only from code zero, ending the search
    a_r5_fail_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cal_fail_o) |-> ((trim_code_o == '0) && $fell(cal_pending_o)));

    // R5: fail and busy never coexist
    a_r5_fail_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cal_fail_o |-> !cal_pending_o);

    // R7: every new search starts at the top code with fail cleared
    a_r7_fresh_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cal_pending_o) |-> ((trim_code_o == '1) && !cal_fail_o));

endmodule

bind vco_trim_seq vts_checker #(.TRIM_W(TRIM_W)) i_vts_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .trim_code_o   (trim_code_o),
    .vco_trim_o    (vco_trim_o),
    .cal_pending_o (cal_pending_o),
    .cal_fail_o    (cal_fail_o),
    .wait_done_i   (wait_done)
);

// File: tb/test_vco_trim_seq.sv
`timescale 1ns/1ps
module test_vco_trim_seq;

    localparam int TW   = 3;
    localparam int WAIT = 16;
    localparam int MAXC = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          cmp = 1'b1;
    logic [TW-1:0] code, trim;
    logic          pending, fail;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;

    always #2.5 clk = ~clk;

    vco_trim_seq #(.TRIM_W(TW), .WAIT_CYCLES(WAIT)) i_vco_trim_seq (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .cal_req_i     (req),
        .cmp_above_i   (cmp),
        .trim_code_o   (code),
        .vco_trim_o    (trim),
        .cal_pending_o (pending),
        .cal_fail_o    (fail)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: a two-sample delay line for the comparator,
    // a tick count per code, and the search rules.
    int m_code, m_trim, m_busy, m_fail, m_tick, m_c1, m_c2, m_reqp, m_seen, m_rise;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = MAXC; m_trim = 0; m_busy = 1; m_fail = 0; m_tick = 0;
            m_c1 = 0; m_c2 = 0; m_reqp = 0;
        end else begin
            m_seen = m_c2; m_c2 = m_c1; m_c1 = cmp;
            m_rise = (req && !m_reqp) ? 1 : 0;
            m_reqp = req;
            if (m_busy != 0) begin
                if (m_tick == WAIT - 1) begin
                    m_tick = 0;
                    if (m_seen != 0) begin
                        m_trim = m_code; m_busy = 0;
                    end else if (m_code == 0) begin
                        m_fail = 1; m_busy = 0;
                    end else begin
                        m_code = m_code - 1;
                    end
                end else begin
                    m_tick = m_tick + 1;
                end
            end else if (m_rise != 0) begin
                m_busy = 1; m_code = MAXC; m_fail = 0; m_tick = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 model code", int'(code), m_code);
            chk("R2 model trim", int'(trim), m_trim);
            chk("R7 model busy", int'(pending), m_busy);
            chk("R5 model fail", int'(fail), m_fail);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic wait_idle(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (pending === 1'b1);
    endtask

    task automatic wait_code(input int c);
        while (int'(code) != c) @(negedge clk);
    endtask

    task automatic pulse_req();
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 code", int'(code), MAXC);
        chk("R1 busy", int'(pending), 1);
        chk("R1 fail", int'(fail), 0);
        chk("R1 trim", int'(trim), 0);
        rst_n = 1'b1;

        // Power-up search, comparator already high: success at top code
        wait_idle(n);
        chk("R3 dwell", n, WAIT);
        chk("R2 trim top", int'(trim), MAXC);

        // Mid-range success, with a request during the search
        cmp = 1'b0;
        pulse_req();
        chk("R7 start code", int'(code), MAXC);
        chk("R7 start busy", int'(pending), 1);
        wait_code(6);
        pulse_req();
        chk("R8 code kept", int'(code), 6);
        chk("R8 busy kept", int'(pending), 1);
        wait_code(4);
        repeat (3) @(negedge clk);
        cmp = 1'b1;
        wait_idle(n);
        chk("R2 trim mid", int'(trim), 4);
        chk("R2 no fail", int'(fail), 0);

        // Exhaustion, request held high afterwards
        cmp = 1'b0;
        req = 1'b1;
        wait_idle(n);
        chk("R6 total time", n, 8 * WAIT + 1);
        chk("R5 fail", int'(fail), 1);
        chk("R5 code zero", int'(code), 0);
        chk("R5 trim kept", int'(trim), 4);
        repeat (40) @(negedge clk);
        chk("R9 no restart", int'(pending), 0);
        chk("R9 fail held", int'(fail), 1);

        // Fresh search after failure, success only at code zero
        req = 1'b0;
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        chk("R7 fresh code", int'(code), MAXC);
        chk("R7 fail cleared", int'(fail), 0);
        chk("R7 busy", int'(pending), 1);
        req = 1'b0;
        wait_code(0);
        repeat (2) @(negedge clk);
        cmp = 1'b1;
        wait_idle(n);
        chk("R4 trim zero", int'(trim), 0);
        chk("R4 no fail at zero", int'(fail), 0);

        // Glitch in mid-wait must not be taken
        cmp = 1'b0;
        pulse_req();
        repeat (3) @(negedge clk);
        cmp = 1'b1;
        repeat (4) @(negedge clk);
        cmp = 1'b0;
        wait_code(5);
        repeat (2) @(negedge clk);
        cmp = 1'b1;
        wait_idle(n);
        chk("R3 glitch ignored", int'(trim), 5);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule